// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a parameterised set of interrupt sources and presents one active-low request line to a single processor core. Each source carries its own programmable vector, priority level and trigger type (edge or level). When the core answers the request it reads the vector register. That read returns the vector of the highest-priority enabled source that stands strictly above the level now in service. Interrupts nest through an internal stack of previous contexts. An end-of-interrupt write unwinds one level.

If the vector register is read when no qualifying source is pending, the block returns a software-programmed spurious vector. It then keeps the request line inactive until software writes end-of-interrupt. This covers a level source that drops just as the core responds, a source disabled while its request is being taken, and a read made with nothing pending. A protect input makes vector reads free of side effects, which suits a debugger. In that mode the interrupt is taken only when the vector register is then written.

Top module: `vpic_top`

## Requirements
- R1: After reset the request output `irq_n` is high, every source is disabled, the status register (offset 1) reads 0 and the enabled-pending register (offset 6) reads 0.
- R2: A read of the vector register (offset 0) returns the vector of the enabled pending source with the highest priority, where a numerically larger priority is more urgent. Between sources of equal priority the lowest source index wins.
- R3: In normal mode (`protect_en` low) that read takes the interrupt in the same access. The status register then reports the source number in bits [SRC_W-1:0] and bit 16 set, and the latched edge request of that source is cleared.
- R4: Only a source with strictly higher priority than the one in service can preempt and be stacked. A source of equal or lower priority leaves `irq_n` high and waits. The stack holds one entry per priority level, so a full nest of all levels fits.
- R5: A write of any data to the end-of-interrupt register (offset 2) restores the previously interrupted context. A waiting source then requests again.
- R6: A vector read with no qualifying source returns the spurious vector held at offset 5 and sets status bit 17. From then on `irq_n` stays high, even with sources pending, until an end-of-interrupt write clears that bit without unwinding the stack.
- R7: With `protect_en` high, a vector read returns the same vector as in normal mode. It leaves the status register, the latched requests and `irq_n` unchanged, and it does not set the spurious bit.
- R8: With `protect_en` high, a vector-register write after a vector read commits the outcome of that read: either the interrupt is taken as in R3, or spurious handling is entered as in R6.
- R9: In normal mode a write to the vector register has no effect on the status register or on `irq_n`.
- R10: Source configuration at offset 8+i holds the vector in bits [VEC_W-1:0], the priority in bits [VEC_W+PRIO_W-1:VEC_W] and the trigger type in bit VEC_W+PRIO_W (1 = level). An edge source latches a rising edge until it is taken. A level source follows its live input, so if the input drops before the vector read, the read is spurious.
- R11: A disabled source never requests. An edge that arrives while the source is disabled stays latched and requests once the source is enabled through the set-enable mask write (offset 3). If the source is disabled through the clear-enable mask write (offset 4) before the vector read, the read is spurious.
- R12: An end-of-interrupt write with an empty stack leaves the block idle (status 0) and able to take the next interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Interrupt sources, synchronous to clk, active high |
| protect_en | input | 1 | Debugger-safe mode: vector reads have no side effects |
| reg_rd | input | 1 | Register read strobe; side effects commit at the clock edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the cycle of reg_rd |
| irq_n | output | 1 | Active-low interrupt request to the core |

## Verification
The bench builds the block with its defaults: eight sources, three priority bits (eight levels and an eight-entry stack), 16-bit vectors and a 32-bit data path. Since there are as many sources as levels, one source per priority can be taken in turn until the stack is full. The whole nest can then be unwound and popped once more on empty. Mixed priorities on the first sources cover the equal-priority tie, preemption and waiting. One source is reconfigured as level-triggered to show the live-input and drop-to-spurious cases.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
   // register offsets
   localparam int A_VEC   = 0;
   localparam int A_STAT  = 1;
   localparam int A_EOI   = 2;
   localparam int A_ENSET = 3;
   localparam int A_ENCLR = 4;
   localparam int A_SPUR  = 5;
   localparam int A_PEND  = 6;
   localparam int A_CFG   = 8;
   // status fields
   localparam int STAT_INSVC_BIT = 16;
   localparam int STAT_SPUR_BIT  = 17;
endpackage

// File: rtl/vpic_src_bank.sv
module vpic_src_bank #(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 3,
   parameter int VEC_W   = 16,
   parameter int DATA_W  = 32,
   parameter int SRC_W   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        irq_in,
   input  logic                      cfg_we,
   input  logic [SRC_W-1:0]          cfg_idx,
   input  logic [DATA_W-1:0]         cfg_data,
   input  logic                      en_set_we,
   input  logic                      en_clr_we,
   input  logic                      ack_we,
   input  logic [SRC_W-1:0]          ack_idx,
   output logic [NUM_SRC-1:0]        req,
   output logic [NUM_SRC*VEC_W-1:0]  vec_flat,
   output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
   localparam int LVL_BIT = VEC_W + PRIO_W;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic [VEC_W-1:0]  vec_q;
      logic [PRIO_W-1:0] prio_q;
      logic              lvl_q, en_q, prev_q, edge_q;
      logic              sel, rise, clr;

      assign sel  = cfg_we && (cfg_idx == SRC_W'(i));
      assign rise = irq_in[i] & ~prev_q;
      assign clr  = ack_we && (ack_idx == SRC_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vec_q  <= '0;
            prio_q <= '0;
            lvl_q  <= 1'b0;
            en_q   <= 1'b0;
            prev_q <= 1'b0;
            edge_q <= 1'b0;
         end else begin
            if (sel) begin
               vec_q  <= cfg_data[VEC_W-1:0];
               prio_q <= cfg_data[VEC_W +: PRIO_W];
               lvl_q  <= cfg_data[LVL_BIT];
            end
            if (en_set_we && cfg_data[i])
               en_q <= 1'b1;
            else if (en_clr_we && cfg_data[i])
               en_q <= 1'b0;
            prev_q <= irq_in[i];
            edge_q <= rise | (edge_q & ~clr);
         end
      end

      assign req[i] = en_q & (lvl_q ? irq_in[i] : edge_q);
      assign vec_flat[i*VEC_W +: VEC_W]    = vec_q;
      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q;
   end
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 3,
   parameter int SRC_W   = 3
) (
   input  logic [NUM_SRC-1:0]        req,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
   input  logic                      cur_valid,
   input  logic [PRIO_W-1:0]         cur_prio,
   output logic                      cand_ok,
   output logic [SRC_W-1:0]          cand_idx,
   output logic [PRIO_W-1:0]         cand_prio
);
   logic found;

   // scan upward so that an equal priority never displaces a lower index
   always_comb begin
      found     = 1'b0;
      cand_idx  = '0;
      cand_prio = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] > cand_prio)) begin
            found     = 1'b1;
            cand_idx  = SRC_W'(i);
            cand_prio = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
      cand_ok = found && (!cur_valid || cand_prio > cur_prio);
   end
endmodule

// File: rtl/vpic_nest_stack.sv
module vpic_nest_stack #(
   parameter int DEPTH = 8,
   parameter int CTX_W = 7
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             push,
   input  logic [CTX_W-1:0]                 push_ctx,
   input  logic                             pop,
   output logic [CTX_W-1:0]                 top_ctx,
   output logic [$clog2(DEPTH+1)-1:0]       depth,
   output logic                             full
);
   localparam int DEP_W = $clog2(DEPTH + 1);
   localparam int IDX_W = $clog2(DEPTH);

   logic [CTX_W-1:0] mem [DEPTH];
   logic [CTX_W-1:0] top_q;
   logic [DEP_W-1:0] depth_q;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic             do_push;

   assign wr_idx  = depth_q[IDX_W-1:0];
   assign rd_idx  = wr_idx - 1'b1;
   assign full    = (depth_q == DEP_W'(DEPTH));
   assign do_push = push && !full;

   always_ff @(posedge clk) begin
      if (do_push)
         mem[wr_idx] <= top_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q   <= '0;
         depth_q <= '0;
      end else if (do_push) begin
         top_q   <= push_ctx;
         depth_q <= depth_q + 1'b1;
      end else if (pop) begin
         if (depth_q != '0) begin
            top_q   <= mem[rd_idx];
            depth_q <= depth_q - 1'b1;
         end else begin
            top_q   <= '0;
         end
      end
   end

   assign top_ctx = top_q;
   assign depth   = depth_q;
endmodule

// File: rtl/vpic_top.sv
module vpic_top
   import vpic_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 3,
   parameter int VEC_W   = 16,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               protect_en,
   input  logic               reg_rd,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq_n
);
   localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int LEVELS = 1 << PRIO_W;
   localparam int CTX_W  = 1 + PRIO_W + SRC_W;
   localparam int DEP_W  = $clog2(LEVELS + 1);

   // elaboration checks
   if (NUM_SRC < 2)                      $error("NUM_SRC must be at least 2");
   if (PRIO_W < 1)                       $error("PRIO_W must be at least 1");
   if (SRC_W > STAT_INSVC_BIT)           $error("too many sources for status layout");
   if (DATA_W < STAT_SPUR_BIT + 1)       $error("DATA_W too narrow for status");
   if (DATA_W < VEC_W + PRIO_W + 1)      $error("DATA_W too narrow for source config");
   if (DATA_W < NUM_SRC)                 $error("DATA_W too narrow for enable masks");
   if ((1 << ADDR_W) < A_CFG + NUM_SRC)  $error("ADDR_W too narrow for register map");

   // register decode
   logic vec_rd, vec_wr, eoi_wr, enset_wr, enclr_wr, spur_wr, cfg_we;
   logic [ADDR_W-1:0] cfg_off;
   logic [SRC_W-1:0]  cfg_idx;

   assign vec_rd   = reg_rd && (reg_addr == ADDR_W'(A_VEC));
   assign vec_wr   = reg_wr && (reg_addr == ADDR_W'(A_VEC));
   assign eoi_wr   = reg_wr && (reg_addr == ADDR_W'(A_EOI));
   assign enset_wr = reg_wr && (reg_addr == ADDR_W'(A_ENSET));
   assign enclr_wr = reg_wr && (reg_addr == ADDR_W'(A_ENCLR));
   assign spur_wr  = reg_wr && (reg_addr == ADDR_W'(A_SPUR));
   assign cfg_off  = reg_addr - ADDR_W'(A_CFG);
   assign cfg_we   = reg_wr && (reg_addr >= ADDR_W'(A_CFG)) && (cfg_off < ADDR_W'(NUM_SRC));
   assign cfg_idx  = cfg_off[SRC_W-1:0];

   // sources
   logic [NUM_SRC-1:0]        req;
   logic [NUM_SRC*VEC_W-1:0]  vec_flat;
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic                      push, pop;
   logic [SRC_W-1:0]          ack_idx;

   vpic_src_bank #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W),
      .DATA_W(DATA_W), .SRC_W(SRC_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(reg_wdata),
      .en_set_we(enset_wr), .en_clr_we(enclr_wr),
      .ack_we(push), .ack_idx(ack_idx),
      .req(req), .vec_flat(vec_flat), .prio_flat(prio_flat)
   );

   // nesting context
   logic [CTX_W-1:0]  top_ctx, push_ctx;
   logic [DEP_W-1:0]  depth;
   logic              full;
   logic              cur_valid;
   logic [PRIO_W-1:0] cur_prio;
   logic [SRC_W-1:0]  cur_src;

   assign cur_valid = top_ctx[CTX_W-1];
   assign cur_prio  = top_ctx[SRC_W +: PRIO_W];
   assign cur_src   = top_ctx[SRC_W-1:0];

   vpic_nest_stack #(.DEPTH(LEVELS), .CTX_W(CTX_W)) u_stack (
      .clk(clk), .rst_n(rst_n), .push(push), .push_ctx(push_ctx),
      .pop(pop), .top_ctx(top_ctx), .depth(depth), .full(full)
   );

   // arbitration
   logic              cand_ok;
   logic [SRC_W-1:0]  cand_idx;
   logic [PRIO_W-1:0] cand_prio;

   vpic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_arb (
      .req(req), .prio_flat(prio_flat), .cur_valid(cur_valid), .cur_prio(cur_prio),
      .cand_ok(cand_ok), .cand_idx(cand_idx), .cand_prio(cand_prio)
   );

   // control state
   logic              spur_lock_q, irq_n_q;
   logic [VEC_W-1:0]  spur_vec_q;
   logic              cap_valid_q, cap_take_q;
   logic [SRC_W-1:0]  cap_idx_q;
   logic [PRIO_W-1:0] cap_prio_q;
   logic              eff_cand, take_norm, spur_norm, commit, take_prot, spur_prot;
   logic [PRIO_W-1:0] push_prio;

   assign eff_cand  = cand_ok & ~spur_lock_q;
   assign take_norm = !protect_en && vec_rd && eff_cand;
   assign spur_norm = !protect_en && vec_rd && !eff_cand;
   assign commit    = protect_en && vec_wr && cap_valid_q;
   assign take_prot = commit && cap_take_q;
   assign spur_prot = commit && !cap_take_q;
   assign push      = take_norm | take_prot;
   assign pop       = eoi_wr && !spur_lock_q;
   assign ack_idx   = take_norm ? cand_idx : cap_idx_q;
   assign push_prio = take_norm ? cand_prio : cap_prio_q;
   assign push_ctx  = {1'b1, push_prio, ack_idx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spur_lock_q <= 1'b0;
         irq_n_q     <= 1'b1;
         spur_vec_q  <= '0;
         cap_valid_q <= 1'b0;
         cap_take_q  <= 1'b0;
         cap_idx_q   <= '0;
         cap_prio_q  <= '0;
      end else begin
         if (spur_wr)
            spur_vec_q <= reg_wdata[VEC_W-1:0];
         if (eoi_wr)
            spur_lock_q <= 1'b0;
         else if (spur_norm || spur_prot)
            spur_lock_q <= 1'b1;
         if (protect_en && vec_rd) begin
            cap_valid_q <= 1'b1;
            cap_take_q  <= eff_cand;
            cap_idx_q   <= cand_idx;
            cap_prio_q  <= cand_prio;
         end else if (vec_wr || !protect_en) begin
            cap_valid_q <= 1'b0;
         end
         irq_n_q <= ~eff_cand;
      end
   end

   assign irq_n = irq_n_q;

   // read data
   logic [DATA_W-1:0] stat_word;

   always_comb begin
      stat_word                 = '0;
      stat_word[SRC_W-1:0]      = cur_src;
      stat_word[STAT_INSVC_BIT] = cur_valid;
      stat_word[STAT_SPUR_BIT]  = spur_lock_q;
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_VEC))
         reg_rdata = DATA_W'(eff_cand ? vec_flat[cand_idx*VEC_W +: VEC_W] : spur_vec_q);
      else if (reg_addr == ADDR_W'(A_STAT))
         reg_rdata = stat_word;
      else if (reg_addr == ADDR_W'(A_SPUR))
         reg_rdata = DATA_W'(spur_vec_q);
      else if (reg_addr == ADDR_W'(A_PEND))
         reg_rdata = DATA_W'(req);
   end
endmodule

// File: rtl/vpic_checker.sv
module vpic_checker #(
   parameter int PRIO_W = 3,
   parameter int SRC_W  = 3,
   parameter int DEP_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              protect_en,
   input logic              vec_rd,
   input logic              vec_wr,
   input logic              eoi_wr,
   input logic              spur_lock,
   input logic              irq_n,
   input logic              push,
   input logic [PRIO_W-1:0] push_prio,
   input logic              full,
   input logic [DEP_W-1:0]  depth,
   input logic              cur_valid,
   input logic [PRIO_W-1:0] cur_prio,
   input logic [SRC_W-1:0]  cur_src
);
   AST_SPUR_BLOCKS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      (spur_lock && $past(spur_lock)) |-> irq_n);                                   // R6

   AST_NEST_STRICTLY_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!cur_valid || push_prio > cur_prio));                               // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);                                                              // R4

   AST_PROTECT_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (protect_en && vec_rd) |=> ($stable(cur_valid) && $stable(cur_src) && $stable(spur_lock))); // R7

   AST_NORMAL_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!protect_en && vec_wr) |=> ($stable(cur_valid) && $stable(cur_src) && $stable(depth)));    // R9

   AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && !spur_lock && depth == '0) |=> !cur_valid);                        // R12
endmodule

bind vpic_top vpic_checker #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .DEP_W(DEP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .protect_en(protect_en), .vec_rd(vec_rd),
   .vec_wr(vec_wr), .eoi_wr(eoi_wr), .spur_lock(spur_lock_q), .irq_n(irq_n),
   .push(push), .push_prio(push_prio), .full(full), .depth(depth),
   .cur_valid(cur_valid), .cur_prio(cur_prio), .cur_src(cur_src)
);

// File: tb/tb_vpic_top.sv
module tb_vpic_top;
   localparam int NSRC = 8;
   localparam int DW   = 32;
   localparam int AW   = 5;
   localparam logic [DW-1:0] SPV = 32'h0000_DEAD;
   localparam logic [DW-1:0] INS = 32'h0001_0000;
   localparam logic [DW-1:0] SPB = 32'h0002_0000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] irq_in = '0;
   logic            protect_en = 1'b0;
   logic            reg_rd = 1'b0, reg_wr = 1'b0;
   logic [AW-1:0]   reg_addr = '0;
   logic [DW-1:0]   reg_wdata = '0;
   logic [DW-1:0]   reg_rdata;
   logic            irq_n;

   always #10 clk = ~clk;

   vpic_top #(.NUM_SRC(NSRC), .PRIO_W(3), .VEC_W(16), .DATA_W(DW), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .protect_en(protect_en),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
   );

   typedef struct {
      logic [DW-1:0] val;
      string         tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_run = 0, n_fail = 0;

   // monitor: compares every read against the scoreboard
   always @(negedge clk) begin
      if (reg_rd) begin
         exp_t e;
         n_run++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL %s unexpected read: actual %h expected none", "R1", reg_rdata);
         end else begin
            e = exp_q.pop_front();
            if (reg_rdata !== e.val) begin
               n_fail++;
               $display("FAIL %s addr %0d: actual %h expected %h", e.tag, reg_addr, reg_rdata, e.val);
            end
         end
      end
   end

   task automatic rd_chk(input int addr, input logic [DW-1:0] v, input string tag);
      exp_t e;
      e.val = v; e.tag = tag;
      @(posedge clk); #1;
      exp_q.push_back(e);
      reg_rd = 1'b1; reg_addr = AW'(addr);
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic wr(input int addr, input logic [DW-1:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = AW'(addr); reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic pulse(input logic [NSRC-1:0] m);
      @(posedge clk); #1;
      irq_in = irq_in | m;
      @(posedge clk); #1;
      irq_in = irq_in & ~m;
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_irq(input logic v, input string tag);
      settle();
      n_run++;
      if (irq_n !== v) begin
         n_fail++;
         $display("FAIL %s irq_n: actual %b expected %b", tag, irq_n, v);
      end
   endtask

   function automatic logic [DW-1:0] cfg(input int idx, input int pr, input bit lvl);
      return (DW'(lvl) << 19) | (DW'(pr) << 16) | DW'(32'h100 + idx);
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int pr [NSRC] = '{0, 1, 3, 2, 4, 3, 6, 7};
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk_irq(1'b1, "R1");
      rd_chk(1, 0, "R1");
      rd_chk(6, 0, "R1");

      wr(5, SPV);
      for (int i = 0; i < NSRC; i++) wr(8 + i, cfg(i, pr[i], 1'b0));
      wr(3, 32'hF7);

      // R2 tie, R3 acknowledge, R4 equal waits
      pulse(8'h26);
      chk_irq(1'b0, "R10");
      rd_chk(0, 32'h102, "R2");
      chk_irq(1'b1, "R4");
      rd_chk(1, INS | 2, "R3");
      rd_chk(6, 32'h22, "R3");
      // R5 unwind then next
      wr(2, 0);
      chk_irq(1'b0, "R5");
      rd_chk(0, 32'h105, "R2");
      rd_chk(1, INS | 5, "R3");
      pulse(8'h40);
      chk_irq(1'b0, "R4");
      rd_chk(0, 32'h106, "R4");
      wr(2, 0);
      rd_chk(1, INS | 5, "R5");
      wr(2, 0);
      rd_chk(0, 32'h101, "R5");
      wr(2, 0);
      rd_chk(1, 0, "R5");

      // R6 spurious and request hold-off
      rd_chk(0, SPV, "R6");
      rd_chk(1, SPB, "R6");
      pulse(8'h10);
      chk_irq(1'b1, "R6");
      wr(2, 0);
      chk_irq(1'b0, "R6");
      rd_chk(0, 32'h104, "R6");
      wr(2, 0);

      // R7 / R8 protect mode
      protect_en = 1'b1;
      pulse(8'h40);
      rd_chk(0, 32'h106, "R7");
      rd_chk(1, 0, "R7");
      chk_irq(1'b0, "R7");
      rd_chk(0, 32'h106, "R7");
      wr(0, 32'h1234);
      rd_chk(1, INS | 6, "R8");
      chk_irq(1'b1, "R8");
      rd_chk(6, 0, "R8");
      wr(2, 0);
      rd_chk(0, SPV, "R7");
      rd_chk(1, 0, "R7");
      wr(0, 0);
      rd_chk(1, SPB, "R8");
      wr(2, 0);
      rd_chk(1, 0, "R8");
      protect_en = 1'b0;

      // R9 vector write ignored in normal mode
      pulse(8'h20);
      wr(0, 32'hFFFF);
      rd_chk(1, 0, "R9");
      chk_irq(1'b0, "R9");
      rd_chk(0, 32'h105, "R9");
      wr(2, 0);

      // R10 level source
      wr(8 + 7, cfg(7, 7, 1'b1));
      @(posedge clk); #1 irq_in[7] = 1'b1;
      chk_irq(1'b0, "R10");
      rd_chk(0, 32'h107, "R10");
      rd_chk(1, INS | 7, "R10");
      chk_irq(1'b1, "R10");
      wr(2, 0);
      chk_irq(1'b0, "R10");
      @(posedge clk); #1 irq_in[7] = 1'b0;
      chk_irq(1'b1, "R10");
      rd_chk(0, SPV, "R10");
      wr(2, 0);

      // R11 enable handling
      pulse(8'h08);
      chk_irq(1'b1, "R11");
      rd_chk(6, 0, "R11");
      wr(3, 32'h08);
      chk_irq(1'b0, "R11");
      rd_chk(6, 32'h08, "R11");
      wr(4, 32'h08);
      rd_chk(0, SPV, "R11");
      wr(2, 0);
      wr(3, 32'h08);
      rd_chk(0, 32'h103, "R11");
      wr(2, 0);
      rd_chk(1, 0, "R11");

      // R4/R5/R12 full nest across all levels
      for (int i = 0; i < NSRC; i++) wr(8 + i, cfg(i, i, 1'b0));
      wr(3, 32'hFF);
      for (int i = 0; i < NSRC; i++) begin
         pulse(NSRC'(1) << i);
         rd_chk(0, 32'h100 + i, "R4");
         rd_chk(1, INS | DW'(i), "R4");
      end
      pulse(8'h08);
      chk_irq(1'b1, "R4");
      for (int i = NSRC - 1; i >= 1; i--) begin
         wr(2, 0);
         rd_chk(1, INS | DW'(i - 1), "R5");
      end
      wr(2, 0);
      rd_chk(1, 0, "R5");
      wr(2, 0);
      rd_chk(1, 0, "R12");
      rd_chk(0, 32'h103, "R12");
      wr(2, 0);
      rd_chk(1, 0, "R12");

      settle();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule